// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block gives one processor an atomic read-modify-write without holding any bus or cache line. A load-linked request reads a word and records a reservation: a valid bit plus the word address. A later store-conditional to that address is allowed to write only if nothing has broken the reservation in the meantime. A context switch or a snooped invalidation that hits the reserved address breaks it. When the reservation is broken, the conditional store is cancelled. No write strobe leaves the block, and the storage keeps its old contents.

Software builds a lock from it in the usual way. It load-links the lock word and retries while the word is nonzero. It then store-conditionals a 1 and retries if the returned flag is 0. The block contains the reservation register, the judgement logic for conditional stores and a small reset-cleared word store that stands in for memory. Every request is answered exactly one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: After synchronous reset the reservation is invalid, `rsp_valid` and `mem_we` are low, and every word of the store reads as zero.
- R2: A request with `req_op` = 2'b10 (load-linked) returns the word at `req_addr` on `rsp_data` in the next cycle and makes the reservation valid with that address.
- R3: `req_op` = 2'b00 (load) returns the addressed word and `req_op` = 2'b01 (store) writes `req_wdata` with `mem_we` high in the request cycle. Neither of them changes the reservation.
- R4: A store-conditional (`req_op` = 2'b11) whose address equals a valid reservation writes `req_wdata` with `mem_we` high in the request cycle. In the next cycle it answers with `sc_ok` = 1 and `rsp_data` = 1.
- R5: A store-conditional with no valid reservation, or with a different address, keeps `mem_we` low and leaves the store unchanged. It answers `sc_ok` = 0 and `rsp_data` = 0.
- R6: Every store-conditional invalidates the reservation, whether it succeeds or fails.
- R7: A `ctx_switch` pulse invalidates the reservation. A store-conditional in the same cycle as the pulse fails.
- R8: An invalidation (`inv_valid`) whose `inv_addr` equals the reserved address invalidates the reservation. An invalidation to any other address leaves it intact.
- R9: An invalidation to the same address as a store-conditional in the same cycle makes it fail. An invalidation to the same address as a load-linked in the same cycle leaves the reservation invalid.
- R10: A new load-linked replaces any earlier reservation.
- R11: `rsp_valid` is high for exactly the one cycle after each accepted request and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Write data for store and store-conditional |
| ctx_switch | input | 1 | Context-switch pulse |
| inv_valid | input | 1 | Snooped invalidation present |
| inv_addr | input | AW | Address of the snooped invalidation |
| mem_we | output | 1 | Write strobe to the word store, request cycle |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_data | output | DW | Read word, or conditional-store result 1/0 |
| sc_ok | output | 1 | Store-conditional succeeded |

## Verification
A wrong reservation state shows up at the ports on the next store-conditional to the address concerned. It either gives a spurious write strobe in that request cycle or returns a wrong result flag one cycle later. A reservation that was left alive wrongly shows up as a second success on the same link. A corrupted store shows up on the next load of that word. The sweeps pair every load-linked address with every conditional-store, invalidation and context-switch case, so each reservation error reaches a port within two requests.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LL    = 2'b10,
        OP_SC    = 2'b11
    } mem_op_e;

    function automatic logic op_reads(input mem_op_e op);
        return (op == OP_LOAD) || (op == OP_LL);
    endfunction

endpackage

// File: rtl/llsc_link_reg.sv
module llsc_link_reg #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ll_set,
    input  logic [AW-1:0] ll_addr,
    input  logic          sc_clear,
    input  logic          ctx_clear,
    input  logic          inv_vld,
    input  logic [AW-1:0] inv_addr,
    output logic          link_vld,
    output logic [AW-1:0] link_addr
);
    logic          vld_d;
    logic [AW-1:0] addr_d;
    logic          hit_held;
    logic          hit_new;

    always_comb begin
        hit_held = inv_vld && link_vld && (inv_addr == link_addr);
        hit_new  = inv_vld && (inv_addr == ll_addr);
        vld_d    = link_vld;
        addr_d   = link_addr;
        if (ctx_clear) begin
            vld_d = 1'b0;
        end else if (ll_set) begin
            vld_d  = !hit_new;
            addr_d = ll_addr;
        end else if (sc_clear || hit_held) begin
            vld_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_vld  <= 1'b0;
            link_addr <= '0;
        end else begin
            link_vld  <= vld_d;
            link_addr <= addr_d;
        end
    end
endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge #(
    parameter int AW = 4
) (
    input  logic          is_sc,
    input  logic [AW-1:0] sc_addr,
    input  logic          link_vld,
    input  logic [AW-1:0] link_addr,
    input  logic          ctx_clear,
    input  logic          inv_vld,
    input  logic [AW-1:0] inv_addr,
    output logic          sc_pass
);
    logic link_match;
    logic broken_now;

    always_comb begin
        link_match = link_vld && (link_addr == sc_addr);
        broken_now = ctx_clear || (inv_vld && (inv_addr == sc_addr));
        sc_pass    = is_sc && link_match && !broken_now;
    end
endmodule

// File: rtl/llsc_word_store.sv
module llsc_word_store #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (we && (addr == AW'(g))) begin
                words[g] <= wdata;
            end
        end
    end

    assign rdata = words[addr];
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ctx_switch,
    input  logic          inv_valid,
    input  logic [AW-1:0] inv_addr,
    output logic          mem_we,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          sc_ok
);
    mem_op_e       op;
    logic          is_ll;
    logic          is_sc;
    logic          is_st;
    logic          sc_pass;
    logic          link_vld;
    logic [AW-1:0] link_addr;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] rsp_d;

    assign op    = mem_op_e'(req_op);
    assign is_ll = req_valid && (op == OP_LL);
    assign is_sc = req_valid && (op == OP_SC);
    assign is_st = req_valid && (op == OP_STORE);

    llsc_link_reg #(.AW(AW)) u_link (
        .clk       (clk),
        .rst       (rst),
        .ll_set    (is_ll),
        .ll_addr   (req_addr),
        .sc_clear  (is_sc),
        .ctx_clear (ctx_switch),
        .inv_vld   (inv_valid),
        .inv_addr  (inv_addr),
        .link_vld  (link_vld),
        .link_addr (link_addr)
    );

    llsc_sc_judge #(.AW(AW)) u_judge (
        .is_sc     (is_sc),
        .sc_addr   (req_addr),
        .link_vld  (link_vld),
        .link_addr (link_addr),
        .ctx_clear (ctx_switch),
        .inv_vld   (inv_valid),
        .inv_addr  (inv_addr),
        .sc_pass   (sc_pass)
    );

    assign mem_we = is_st || sc_pass;

    llsc_word_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (rd_word)
    );

    always_comb begin
        if (op_reads(op)) begin
            rsp_d = rd_word;
        end else begin
            rsp_d = DW'(sc_pass);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            sc_ok     <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_data  <= req_valid ? rsp_d : '0;
            sc_ok     <= sc_pass;
        end
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic [AW-1:0] req_addr,
    input logic          ctx_switch,
    input logic          inv_valid,
    input logic [AW-1:0] inv_addr,
    input logic          mem_we,
    input logic          rsp_valid,
    input logic          sc_ok,
    input logic          link_vld,
    input logic [AW-1:0] link_addr
);
    AST_SC_LEAVES_NO_LINK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11 && !ctx_switch) |=> !link_vld); // R6

    AST_CTX_SC_FAILS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11 && ctx_switch) |=> (rsp_valid && !sc_ok)); // R7

    AST_CTX_DROPS_LINK: assert property (@(posedge clk) disable iff (rst)
        ctx_switch |=> !link_vld); // R7

    AST_INV_DROPS_LINK: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && link_vld && inv_addr == link_addr && !(req_valid && req_op == 2'b10))
        |=> !link_vld); // R8

    AST_LL_TAKES_LINK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10 && !ctx_switch && !(inv_valid && inv_addr == req_addr))
        |=> (link_vld && link_addr == $past(req_addr))); // R2

    AST_FAILED_SC_SILENT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_op) == 2'b11 && !sc_ok) |-> !$past(mem_we)); // R5

    AST_WE_ONLY_ON_WRITES: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (req_valid && (req_op == 2'b01 || req_op == 2'b11))); // R3

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R11

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R11
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .ctx_switch (ctx_switch),
    .inv_valid  (inv_valid),
    .inv_addr   (inv_addr),
    .mem_we     (mem_we),
    .rsp_valid  (rsp_valid),
    .sc_ok      (sc_ok),
    .link_vld   (link_vld),
    .link_addr  (link_addr)
);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ctx_switch = 1'b0;
    logic          inv_valid = 1'b0;
    logic [AW-1:0] inv_addr = '0;
    logic          mem_we;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          sc_ok;

    int compared = 0;
    int mismatched = 0;

    logic [DW-1:0] ref_mem [N];
    logic          ref_lv;
    logic [AW-1:0] ref_la;

    always #4 clk = ~clk;

    llsc_monitor #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .ctx_switch(ctx_switch),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .mem_we(mem_we),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sc_ok(sc_ok)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_op(input string tag, input logic [1:0] op, input int addr, input int wd,
                         input logic ctx, input logic iv, input int ia);
        logic exp_pass;
        logic exp_we;
        int   exp_rd;
        @(negedge clk);
        check("R11", "idle rsp_valid", int'(rsp_valid), 0);
        exp_pass = (op == 2'b11) && ref_lv && (ref_la == AW'(addr)) && !ctx
                   && !(iv && AW'(ia) == AW'(addr));
        exp_we   = (op == 2'b01) || exp_pass;
        exp_rd   = (op == 2'b00 || op == 2'b10) ? int'(ref_mem[addr]) : int'(exp_pass);
        req_valid  = 1'b1;
        req_op     = op;
        req_addr   = AW'(addr);
        req_wdata  = DW'(wd);
        ctx_switch = ctx;
        inv_valid  = iv;
        inv_addr   = AW'(ia);
        #1;
        check(tag, "mem_we", int'(mem_we), int'(exp_we));
        if (exp_we) ref_mem[addr] = DW'(wd);
        if (ctx) ref_lv = 1'b0;
        else if (op == 2'b10) begin
            ref_lv = !(iv && AW'(ia) == AW'(addr));
            ref_la = AW'(addr);
        end else if (op == 2'b11) ref_lv = 1'b0;
        else if (iv && ref_lv && AW'(ia) == ref_la) ref_lv = 1'b0;
        @(negedge clk);
        req_valid  = 1'b0;
        ctx_switch = 1'b0;
        inv_valid  = 1'b0;
        check("R11", "rsp_valid", int'(rsp_valid), 1);
        check(tag, "rsp_data", int'(rsp_data), exp_rd);
        if (op == 2'b11) check(tag, "sc_ok", int'(sc_ok), int'(exp_pass));
    endtask

    initial begin
        #(8 * 150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        ref_lv = 1'b0;
        ref_la = '0;
        for (int i = 0; i < N; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        check("R1", "mem_we after reset", int'(mem_we), 0);
        // R1: reservation invalid -> SC fails; store reads zero
        do_op("R1", 2'b11, 5, 8'hAA, 1'b0, 1'b0, 0);
        for (int a = 0; a < N; a++) do_op("R1", 2'b00, a, 0, 1'b0, 1'b0, 0);
        // R3: fill the store
        for (int a = 0; a < N; a++) do_op("R3", 2'b01, a, (a * 7 + 3) & 8'hFF, 1'b0, 1'b0, 0);
        // R2 R4 R5 R6: every LL address against every SC address, then a repeat SC
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                do_op("R2", 2'b10, a, 0, 1'b0, 1'b0, 0);
                do_op((a == b) ? "R4" : "R5", 2'b11, b, ((a * 16 + b) ^ 8'h5A) & 8'hFF, 1'b0, 1'b0, 0);
                do_op("R6", 2'b11, a, 8'h33, 1'b0, 1'b0, 0);
                do_op("R5", 2'b00, b, 0, 1'b0, 1'b0, 0);
            end
        end
        // R3: plain load and store elsewhere keep the link
        for (int a = 0; a < N; a++) begin
            do_op("R2", 2'b10, a, 0, 1'b0, 1'b0, 0);
            do_op("R3", 2'b00, (a + 3) % N, 0, 1'b0, 1'b0, 0);
            do_op("R3", 2'b01, (a + 1) % N, a, 1'b0, 1'b0, 0);
            do_op("R3", 2'b11, a, 8'h01, 1'b0, 1'b0, 0);
        end
        // R7: context switch alone, and together with the SC
        for (int a = 0; a < N; a++) begin
            do_op("R2", 2'b10, a, 0, 1'b0, 1'b0, 0);
            do_op("R7", 2'b00, a, 0, 1'b1, 1'b0, 0);
            do_op("R7", 2'b11, a, 8'h77, 1'b0, 1'b0, 0);
            do_op("R2", 2'b10, a, 0, 1'b0, 1'b0, 0);
            do_op("R7", 2'b11, a, 8'h78, 1'b1, 1'b0, 0);
            do_op("R7", 2'b00, a, 0, 1'b0, 1'b0, 0);
        end
        // R8: invalidation sweep
        for (int a = 0; a < N; a++) begin
            for (int i = 0; i < N; i++) begin
                do_op("R2", 2'b10, a, 0, 1'b0, 1'b0, 0);
                do_op("R8", 2'b00, (a + 5) % N, 0, 1'b0, 1'b1, i);
                do_op("R8", 2'b11, a, (a + i) & 8'hFF, 1'b0, 1'b0, 0);
            end
        end
        // R9: same-cycle invalidation with SC and with LL
        for (int a = 0; a < N; a++) begin
            do_op("R2", 2'b10, a, 0, 1'b0, 1'b0, 0);
            do_op("R9", 2'b11, a, 8'hE1, 1'b0, 1'b1, a);
            do_op("R9", 2'b10, a, 0, 1'b0, 1'b1, a);
            do_op("R9", 2'b11, a, 8'hE2, 1'b0, 1'b0, 0);
            do_op("R9", 2'b10, a, 0, 1'b0, 1'b1, (a + 1) % N);
            do_op("R9", 2'b11, a, 8'hE3, 1'b0, 1'b0, 0);
        end
        // R10: a newer LL replaces the older link
        for (int a = 0; a < N; a++) begin
            do_op("R10", 2'b10, a, 0, 1'b0, 1'b0, 0);
            do_op("R10", 2'b10, (a + 2) % N, 0, 1'b0, 1'b0, 0);
            do_op("R10", 2'b11, a, 8'hC0, 1'b0, 1'b0, 0);
            do_op("R10", 2'b10, a, 0, 1'b0, 1'b0, 0);
            do_op("R10", 2'b10, (a + 2) % N, 0, 1'b0, 1'b0, 0);
            do_op("R10", 2'b11, (a + 2) % N, 8'hC1, 1'b0, 1'b0, 0);
        end
        @(negedge clk);
        check("R11", "final rsp_valid", int'(rsp_valid), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule